// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads a page directory entry and then a page table entry from memory. A caller presents the linear address, a write flag and a user flag. A separate input gives the frame number of the page directory. The walker answers with the physical address, or with a fault that carries a cause code and the level that refused the access.

Both entries must be marked present. User-level accesses are checked against the protection pairs of the two entries. Supervisor accesses pass this check in every case. If the walk succeeds, the walker sets the accessed bit in each entry and the dirty bit in the table entry when the access is a write. It only writes a bit that is still clear. Each such update is a read followed by a write to the same word, and the bus lock is held from the read through the write. All other bits, the software-owned ones included, are written back unchanged.

The memory port moves one 32-bit word per transfer. A request stays asserted with a stable address until the memory acknowledges it. Read data arrives in the acknowledge cycle.

Top module: `xlat_walker`

## Requirements
- R1: The walker accepts a request in a cycle where `req_valid` and `req_ready` are both high. It then holds `req_ready` low until its single response has been given. `rsp_valid` is high for exactly one cycle per request.
- R2: The directory entry is read at byte address {dir_base, lin[31:22], 2'b00}. The table entry is read at {directory entry[31:12], lin[21:12], 2'b00}.
- R3: On success `rsp_fault` is 0, `rsp_cause` is 2'b00 and `rsp_phys` is {table entry[31:12], lin[11:0]}.
- R4: If bit 0 (present) of the directory entry is 0, the response is a fault with cause 2'b01 and `rsp_level` 0, and the table is not read. If bit 0 of the table entry is 0, the response is cause 2'b01 with `rsp_level` 1.
- R5: Bit 2 is U/S and bit 1 is R/W. The effective rights are the numerically smaller of {dir[2],dir[1]} and {tbl[2],tbl[1]}. For a user access: effective U/S 0 gives cause 2'b11, and effective 2'b10 with a write gives cause 2'b10. Both report `rsp_level` 1. A supervisor access is never refused by this check.
- R6: After a granted access, bit 5 (accessed) is 1 in both entries, and bit 6 (dirty) is 1 in the table entry if the access was a write. Bit 6 of the directory entry is never changed.
- R7: Every write to memory has `mem_lock` high. It is preceded by a locked read of the same address, with the lock held continuously from that read through the write.
- R8: A written-back entry equals the value from its locked read with only bits 5 and/or 6 newly set. Software bits 11..9 and all other bits are kept.
- R9: A faulting walk performs no memory write. A walk whose status bits are already set performs no write and never raises `mem_lock`.
- R10: Once `mem_req` is raised, it stays high with the same `mem_addr` and `mem_we` until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-level access |
| dir_base | input | 20 | Frame number of the page directory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation refused |
| rsp_cause | output | 2 | 00 none, 01 not present, 10 write protect, 11 user protect |
| rsp_level | output | 1 | 0 directory, 1 table (valid with a fault) |
| rsp_phys | output | 32 | Physical address (zero on fault) |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write transfer |
| mem_lock | output | 1 | Bus lock for read-modify-write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer done; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
A wrong latched entry or index shows up in one of two places. It appears on `mem_addr` at the table read, or in `rsp_phys` and `rsp_cause` in the response cycle, within the same walk. A bad update mask or a stale read-modify-write buffer corrupts the memory word. The bench catches this by comparing the entries against its own model right after the response. A state machine that drops or reorders the lock, or writes on a faulting walk, is flagged at the write transfer itself by the memory model's lock and write bookkeeping.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int LA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int FRAME_W = LA_W - OFF_W;

  localparam int B_PRES  = 0;
  localparam int B_RW    = 1;
  localparam int B_US    = 2;
  localparam int B_ACC   = 5;
  localparam int B_DIRTY = 6;

  localparam logic [1:0] CAUSE_NONE   = 2'b00;
  localparam logic [1:0] CAUSE_ABSENT = 2'b01;
  localparam logic [1:0] CAUSE_WRITE  = 2'b10;
  localparam logic [1:0] CAUSE_USER   = 2'b11;

  // byte address of the directory word selected by the top index field
  function automatic logic [LA_W-1:0] f_dir_addr(input logic [FRAME_W-1:0] base,
                                                 input logic [LA_W-1:0] lin);
    return {base, lin[LA_W-1 -: IDX_W], 2'b00};
  endfunction

  // byte address of the table word selected by the middle index field
  function automatic logic [LA_W-1:0] f_tbl_addr(input logic [LA_W-1:0] dir_ent,
                                                 input logic [LA_W-1:0] lin);
    return {dir_ent[LA_W-1:OFF_W], lin[OFF_W+IDX_W-1:OFF_W], 2'b00};
  endfunction

  function automatic logic [LA_W-1:0] f_phys(input logic [LA_W-1:0] tbl_ent,
                                             input logic [LA_W-1:0] lin);
    return {tbl_ent[LA_W-1:OFF_W], lin[OFF_W-1:0]};
  endfunction

  // most restrictive of two {U/S,R/W} pairs
  function automatic logic [1:0] f_rights(input logic [1:0] a, input logic [1:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_pkg::*;
(
  input  logic [1:0] dir_rights,
  input  logic [1:0] tbl_rights,
  input  logic       is_user,
  input  logic       is_write,
  output logic       deny,
  output logic [1:0] cause
);
  logic [1:0] eff;

  always_comb begin
    eff   = f_rights(dir_rights, tbl_rights);
    deny  = 1'b0;
    cause = CAUSE_NONE;
    if (is_user) begin
      if (!eff[1]) begin
        deny  = 1'b1;
        cause = CAUSE_USER;
      end else if (is_write && !eff[0]) begin
        deny  = 1'b1;
        cause = CAUSE_WRITE;
      end
    end
  end
endmodule

// File: rtl/xlat_upd.sv
module xlat_upd
  import xlat_pkg::*;
(
  input  logic [LA_W-1:0] entry,
  input  logic            set_dirty,
  output logic [LA_W-1:0] mask,
  output logic            need
);
  always_comb begin
    mask = '0;
    mask[B_ACC]   = 1'b1;
    mask[B_DIRTY] = set_dirty;
    need = ((entry & mask) != mask);
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LA_W-1:0]    req_lin,
  input  logic               req_write,
  input  logic               req_user,
  input  logic [FRAME_W-1:0] dir_base,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [1:0]         rsp_cause,
  output logic               rsp_level,
  output logic [LA_W-1:0]    rsp_phys,
  output logic               mem_req,
  output logic               mem_we,
  output logic               mem_lock,
  output logic [LA_W-1:0]    mem_addr,
  output logic [LA_W-1:0]    mem_wdata,
  input  logic               mem_ack,
  input  logic [LA_W-1:0]    mem_rdata
);
  localparam int LEVELS = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_DIR, S_RD_TBL, S_CHECK,
    S_LRD_DIR, S_LWR_DIR, S_LRD_TBL, S_LWR_TBL, S_RESP
  } st_t;

  st_t                              state_q;
  logic [LA_W-1:0]                  lin_q;
  logic                             wr_q, user_q;
  logic [FRAME_W-1:0]               base_q;
  logic [LEVELS-1:0][LA_W-1:0]      ent_q;
  logic [LA_W-1:0]                  rmw_q;
  logic                             fault_q, level_q;
  logic [1:0]                       cause_q;

  logic [LEVELS-1:0][LA_W-1:0]      upd_mask;
  logic [LEVELS-1:0]                upd_need;
  logic                             perm_deny;
  logic [1:0]                       perm_cause;
  logic                             at_dir;

  // named events for the checker
  logic walk_start, rd_done, wr_done;
  assign walk_start = req_valid && req_ready;
  assign rd_done    = mem_req && !mem_we && mem_ack;
  assign wr_done    = mem_req && mem_we && mem_ack;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    xlat_upd u_upd (
      .entry    (ent_q[lv]),
      .set_dirty((lv == LEVELS-1) && wr_q),
      .mask     (upd_mask[lv]),
      .need     (upd_need[lv])
    );
  end

  xlat_perm u_perm (
    .dir_rights({ent_q[0][B_US], ent_q[0][B_RW]}),
    .tbl_rights({ent_q[1][B_US], ent_q[1][B_RW]}),
    .is_user   (user_q),
    .is_write  (wr_q),
    .deny      (perm_deny),
    .cause     (perm_cause)
  );

  always_comb begin
    req_ready = (state_q == S_IDLE);
    rsp_valid = (state_q == S_RESP);
    mem_req   = (state_q == S_RD_DIR) || (state_q == S_RD_TBL) ||
                (state_q == S_LRD_DIR) || (state_q == S_LWR_DIR) ||
                (state_q == S_LRD_TBL) || (state_q == S_LWR_TBL);
    mem_we    = (state_q == S_LWR_DIR) || (state_q == S_LWR_TBL);
    mem_lock  = (state_q == S_LRD_DIR) || (state_q == S_LWR_DIR) ||
                (state_q == S_LRD_TBL) || (state_q == S_LWR_TBL);
    at_dir    = (state_q == S_RD_DIR) || (state_q == S_LRD_DIR) ||
                (state_q == S_LWR_DIR);
    mem_addr  = at_dir ? f_dir_addr(base_q, lin_q) : f_tbl_addr(ent_q[0], lin_q);
    mem_wdata = rmw_q | (at_dir ? upd_mask[0] : upd_mask[1]);
    rsp_fault = fault_q;
    rsp_cause = cause_q;
    rsp_level = level_q;
    rsp_phys  = fault_q ? '0 : f_phys(ent_q[1], lin_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      lin_q   <= '0;
      wr_q    <= 1'b0;
      user_q  <= 1'b0;
      base_q  <= '0;
      ent_q   <= '0;
      rmw_q   <= '0;
      fault_q <= 1'b0;
      level_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      case (state_q)
        S_IDLE: if (walk_start) begin
          lin_q   <= req_lin;
          wr_q    <= req_write;
          user_q  <= req_user;
          base_q  <= dir_base;
          fault_q <= 1'b0;
          level_q <= 1'b0;
          cause_q <= CAUSE_NONE;
          state_q <= S_RD_DIR;
        end
        S_RD_DIR: if (mem_ack) begin
          ent_q[0] <= mem_rdata;
          if (!mem_rdata[B_PRES]) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_ABSENT;
            level_q <= 1'b0;
            state_q <= S_RESP;
          end else begin
            state_q <= S_RD_TBL;
          end
        end
        S_RD_TBL: if (mem_ack) begin
          ent_q[1] <= mem_rdata;
          if (!mem_rdata[B_PRES]) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_ABSENT;
            level_q <= 1'b1;
            state_q <= S_RESP;
          end else begin
            state_q <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (perm_deny) begin
            fault_q <= 1'b1;
            cause_q <= perm_cause;
            level_q <= 1'b1;
            state_q <= S_RESP;
          end else if (upd_need[0]) begin
            state_q <= S_LRD_DIR;
          end else if (upd_need[1]) begin
            state_q <= S_LRD_TBL;
          end else begin
            state_q <= S_RESP;
          end
        end
        S_LRD_DIR: if (mem_ack) begin
          rmw_q   <= mem_rdata;
          state_q <= S_LWR_DIR;
        end
        S_LWR_DIR: if (mem_ack) begin
          state_q <= upd_need[1] ? S_LRD_TBL : S_RESP;
        end
        S_LRD_TBL: if (mem_ack) begin
          rmw_q   <= mem_rdata;
          state_q <= S_LWR_TBL;
        end
        S_LWR_TBL: if (mem_ack) state_q <= S_RESP;
        S_RESP:    state_q <= S_IDLE;
        default:   state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk
  import xlat_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [1:0]      rsp_cause,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_lock,
  input logic            mem_ack,
  input logic [LA_W-1:0] mem_addr,
  input logic [LA_W-1:0] mem_wdata,
  input logic [LA_W-1:0] mem_rdata,
  input logic            walk_start,
  input logic            rd_done,
  input logic            wr_done
);
  logic [LA_W-1:0] last_rd, last_rd_addr;
  logic            last_rd_locked, wrote;
  logic [LA_W-1:0] stat_mask;

  assign stat_mask = (LA_W'(1) << B_ACC) | (LA_W'(1) << B_DIRTY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_rd        <= '0;
      last_rd_addr   <= '0;
      last_rd_locked <= 1'b0;
      wrote          <= 1'b0;
    end else begin
      if (rd_done) begin
        last_rd        <= mem_rdata;
        last_rd_addr   <= mem_addr;
        last_rd_locked <= mem_lock;
      end
      if (walk_start)   wrote <= 1'b0;
      else if (wr_done) wrote <= 1'b1;
    end
  end

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> !req_ready);
  p_ok_no_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_cause == CAUSE_NONE);
  p_fault_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_cause != CAUSE_NONE);
  p_write_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_lock && last_rd_locked && (mem_addr == last_rd_addr));
  p_wb_keeps_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (((mem_wdata ^ last_rd) & ~stat_mask) == '0) &&
                          ((last_rd & ~mem_wdata) == '0));
  p_fault_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> !wrote);
  p_lock_with_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> mem_req);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_cause (rsp_cause),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_lock  (mem_lock),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .walk_start(walk_start),
  .rd_done   (rd_done),
  .wr_done   (wr_done)
);

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] DBASE = 20'h00040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_lin = '0;
  logic [19:0] dir_base = DBASE;
  logic        rsp_valid, rsp_fault, rsp_level;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_phys;
  logic        mem_req, mem_we, mem_lock;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_walker u_xlat_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lin(req_lin), .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_level(rsp_level), .rsp_phys(rsp_phys), .mem_req(mem_req), .mem_we(mem_we),
    .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int n_chk = 0, n_err = 0;
  int n_wr = 0, n_lock_cyc = 0, n_lock_err = 0, rsp_seen = 0, n_issued = 0;
  int cycles = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // sparse word memory
  logic [31:0] mem [int unsigned];
  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  logic        last_rd_locked = 1'b0;
  logic [31:0] last_rd_addr = '0;

  always @(negedge clk) begin
    if (rst_n && mem_lock) n_lock_cyc++;
    if (mem_ack) mem_ack = 1'b0;
    else if (rst_n && mem_req) begin
      if (mem_we) begin
        n_wr++;
        if (!mem_lock || !last_rd_locked || last_rd_addr != mem_addr) n_lock_err++;
        mem[mem_addr] = mem_wdata;
      end else begin
        mem_rdata      = rd(mem_addr);
        last_rd_locked = mem_lock;
        last_rd_addr   = mem_addr;
      end
      mem_ack = 1'b1;
    end
  end

  typedef struct {
    string       tag;
    logic        fault;
    logic [1:0]  cause;
    logic        level;
    logic [31:0] phys;
  } exp_t;
  exp_t exp_q[$];

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R1 unexpected response", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " fault"}, {31'b0, rsp_fault}, {31'b0, e.fault});
        chk({e.tag, " cause"}, {30'b0, rsp_cause}, {30'b0, e.cause});
        if (e.fault) chk({e.tag, " level"}, {31'b0, rsp_level}, {31'b0, e.level});
        chk({e.tag, " phys"}, rsp_phys, e.phys);
      end
      rsp_seen++;
    end
  end

  function automatic logic [31:0] ent(input logic [19:0] fr, input logic us, input logic rw,
                                      input logic a, input logic d, input logic p,
                                      input logic [2:0] sw);
    return {fr, sw, 2'b00, d, a, 2'b00, us, rw, p};
  endfunction

  function automatic logic [31:0] lin_of(input int di, input int ti, input logic [11:0] off);
    return {di[9:0], ti[9:0], off};
  endfunction

  // driver: model the walk, push expectation, issue, then verify memory
  task automatic walk(input string tag, input logic [31:0] lin, input logic wr, input logic usr);
    exp_t e;
    logic [31:0] pa, ta, pde, pte, npde, npte;
    logic [1:0]  pr, tr, eff;
    int wexp, w0, l0;
    e.tag = tag; e.fault = 1'b0; e.cause = 2'b00; e.level = 1'b0; e.phys = '0;
    pa = {DBASE, lin[31:22], 2'b00};
    pde = rd(pa); npde = pde;
    ta = {pde[31:12], lin[21:12], 2'b00};
    pte = rd(ta); npte = pte;
    if (!pde[0]) begin
      e.fault = 1'b1; e.cause = 2'b01; e.level = 1'b0;
    end else if (!pte[0]) begin
      e.fault = 1'b1; e.cause = 2'b01; e.level = 1'b1;
    end else begin
      pr = {pde[2], pde[1]}; tr = {pte[2], pte[1]};
      eff = (tr < pr) ? tr : pr;
      if (usr && eff[1] == 1'b0) begin
        e.fault = 1'b1; e.cause = 2'b11; e.level = 1'b1;
      end else if (usr && wr && eff == 2'b10) begin
        e.fault = 1'b1; e.cause = 2'b10; e.level = 1'b1;
      end else begin
        npde = pde | 32'h20;
        npte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
        e.phys = {pte[31:12], lin[11:0]};
      end
    end
    wexp = int'(npde != pde) + int'(npte != pte);
    w0 = n_wr; l0 = n_lock_cyc;
    exp_q.push_back(e);
    n_issued++;
    req_lin = lin; req_write = wr; req_user = usr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R1 busy after accept"}, {31'b0, req_ready}, 32'd0);
    while (rsp_seen < n_issued) @(negedge clk);
    chk({tag, " R6 R8 directory word"}, rd(pa), npde);
    if (pde[0]) chk({tag, " R6 R8 table word"}, rd(ta), npte);
    chk({tag, " R9 write count"}, n_wr - w0, wexp);
    if (wexp == 0) chk({tag, " R9 no lock"}, n_lock_cyc - l0, 32'd0);
    chk({tag, " R7 locked rmw"}, n_lock_err, 32'd0);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // directory (frame 0x00040)
    mem[{DBASE, 10'd1, 2'b00}] = ent(20'h00100, 1, 1, 0, 0, 0, 3'b000);
    mem[{DBASE, 10'd2, 2'b00}] = ent(20'h00100, 1, 1, 0, 0, 1, 3'b101);
    mem[{DBASE, 10'd3, 2'b00}] = ent(20'h00200, 1, 0, 1, 0, 1, 3'b010);
    mem[{DBASE, 10'd4, 2'b00}] = ent(20'h00300, 0, 1, 1, 0, 1, 3'b000);
    // table 0x00100
    mem[{20'h00100, 10'd5, 2'b00}] = ent(20'h0AAAA, 1, 1, 1, 1, 0, 3'b000);
    mem[{20'h00100, 10'd6, 2'b00}] = ent(20'h12345, 0, 0, 0, 0, 1, 3'b011);
    mem[{20'h00100, 10'd7, 2'b00}] = ent(20'h23456, 1, 1, 1, 0, 1, 3'b110);
    mem[{20'h00100, 10'd8, 2'b00}] = ent(20'h34567, 1, 0, 1, 0, 1, 3'b001);
    mem[{20'h00100, 10'd9, 2'b00}] = ent(20'h45678, 0, 1, 1, 0, 1, 3'b000);
    // table 0x00200
    mem[{20'h00200, 10'd4, 2'b00}] = ent(20'h56789, 1, 1, 1, 1, 1, 3'b111);
    // table 0x00300
    mem[{20'h00300, 10'd1, 2'b00}] = ent(20'h6789A, 1, 1, 0, 0, 1, 3'b100);

    repeat (3) @(negedge clk);
    chk("R1 reset ready", {31'b0, req_ready}, 32'd1);
    chk("R1 reset no response", {31'b0, rsp_valid}, 32'd0);
    chk("R10 reset no request", {31'b0, mem_req}, 32'd0);
    chk("R7 reset no lock", {31'b0, mem_lock}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    walk("R4 directory absent",        lin_of(1, 0, 12'h010), 0, 0);
    walk("R4 table absent",            lin_of(2, 5, 12'h020), 1, 1);
    walk("R3 R6 sup read sets A",      lin_of(2, 6, 12'hABC), 0, 0);
    walk("R9 repeat no update",        lin_of(2, 6, 12'h123), 0, 0);
    walk("R6 user write sets D",       lin_of(2, 7, 12'hFFF), 1, 1);
    walk("R5 user read ro page",       lin_of(2, 8, 12'h004), 0, 1);
    walk("R5 user write ro page",      lin_of(2, 8, 12'h008), 1, 1);
    walk("R5 merged sup-only table",   lin_of(2, 9, 12'h00C), 0, 1);
    walk("R5 merged ro directory",     lin_of(3, 4, 12'h100), 1, 1);
    walk("R5 user read ro directory",  lin_of(3, 4, 12'h200), 0, 1);
    walk("R5 sup write ro directory",  lin_of(3, 4, 12'h300), 1, 0);
    walk("R5 user sup-only directory", lin_of(4, 1, 12'h044), 0, 1);
    walk("R2 R6 sup write both bits",  lin_of(4, 1, 12'h048), 1, 0);

    repeat (4) @(negedge clk);
    chk("R1 response count", rsp_seen, n_issued);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule